// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter

This block is a memory-mapped timer built around a 32-bit down-counter. Software programs a reload value, a compare value and a control word through a small word-addressed register port; the counter then steps down once every (prescaler + 1) ticks of the chosen timebase. The timebase is either a fast tick or a slow 32 kHz tick, and each is a one-cycle enable pulse in the block's clock domain. When the counter passes the compare value, a sticky status flag is raised. The interrupt line reports that flag when the compare interrupt is enabled.

When the counter is at zero and another decrement tick arrives, the counter restarts. It either reloads from the load register or wraps to all ones, as the reload-mode bit selects. A second control bit makes every write of the load register also overwrite the running count at once. Any write to the status word acknowledges the flag. A self-clearing reset bit in the control word returns the whole block to its power-up state.

Top module: `pit_timer`

## Requirements
- R1: Word offsets read as follows: 0 is control, 1 is status (flag in bit 0, other bits zero), 2 is load, 3 is compare and 4 is the current count. Every other offset reads as zero. Reads are combinational from the address.
- R2: A control write without bit 16 stores the written word with bits 31:26 and bit 16 forced to zero. The fields are: bit 0 enable, bit 1 enable-mode, bit 2 compare interrupt enable, bit 3 reload mode, bits 15:4 prescaler, bit 17 immediate overwrite, bits 25:24 clock source.
- R3: Clock source 00 stops counting. Sources 01 and 10 count on the fast tick input and ignore the slow tick. Source 11 counts on the slow tick and ignores the fast tick.
- R4: While enabled, the counter decrements once every (prescaler + 1) selected ticks. The tick count restarts from zero on every control write.
- R5: A decrement tick that finds the counter at 0 reloads it from the load register when reload mode (bit 3) is 1, and sets it to all ones when reload mode is 0.
- R6: A decrement tick that finds the counter equal to the compare register sets the status flag, and the flag stays set. With compare at 0 this happens at the restart point.
- R7: The interrupt output is high exactly when the status flag is set and the compare interrupt enable (control bit 2) is 1.
- R8: Any write to offset 1 clears the status flag, whatever the data. If a compare event occurs in the same cycle, the flag stays set.
- R9: A control write with enable 1 and enable-mode 0 loads the counter from the load register. With enable-mode 1 the counter keeps its value. With enable 0 the counter holds its value and ignores ticks.
- R10: A write to offset 2 updates the reload value and leaves the count alone. When control bit 17 is 1, the count also takes the written value in the same cycle.
- R11: Hardware reset, and a control write with bit 16 set, both clear control, compare and the flag to 0 and set load and count to all ones. The other bits of that write are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_tick_i | input | 1 | Fast timebase tick, one-cycle pulse |
| lf_tick_i | input | 1 | 32 kHz timebase tick, one-cycle pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Word offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- each decrement steps the count down by exactly one, restarts it from the load register or from all ones as the mode selects, or lets a write override it;
- a compare hit raises the flag, and an acknowledge that arrives without a hit lowers it;
- no decrement occurs while the counter is stopped or has no clock source;
- a nonzero prescaler never allows two decrements in a row;
- a software reset restores every register;
- the interrupt rises only after a hit or a control write.

Some properties need whole stimulus sequences, so only the bench scenarios show them:
- the exact count after a number of ticks on each timebase;
- that the unselected tick input is ignored;
- the hold-versus-load choice of enable-mode;
- the immediate-overwrite option;
- the case where an acknowledge and a compare hit land in the same cycle.

// File: rtl/pit_pkg.sv
// Package: shared constants and types of the periodic down-counter timer.
// Assumes a 32-bit register map; field positions are fixed by the map.
package pit_pkg;
    localparam int DATA_W  = 32;
    localparam int PSC_W   = 12;

    // word offsets of the register map
    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_LOAD = 2;
    localparam int OFS_CMP  = 3;
    localparam int OFS_CNT  = 4;

    // control word bit positions
    localparam int B_EN     = 0;
    localparam int B_ENMOD  = 1;
    localparam int B_OCIEN  = 2;
    localparam int B_RLD    = 3;
    localparam int PSC_LSB  = 4;
    localparam int B_SWR    = 16;
    localparam int B_IOVW   = 17;
    localparam int SRC_LSB  = 24;

    // bits kept on a control write (31:26 and the reset bit drop out)
    localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h03FE_FFFF;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_HS_A = 2'b01,
        SRC_HS_B = 2'b10,
        SRC_LF   = 2'b11
    } clk_src_e;
endpackage

// File: rtl/pit_tick_gen.sv
// Module: timebase selection and prescaler for the down-counter.
// Produces a one-cycle decrement pulse every (psc_i + 1) selected ticks.
// Assumes tick inputs are single-cycle pulses synchronous to clk and that
// psc_i only changes together with restart_i (a control write).
module pit_tick_gen
    import pit_pkg::*;
#(
    parameter int PW = PSC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst_i,
    input  logic          restart_i,
    input  logic          en_i,
    input  logic [1:0]    src_i,
    input  logic [PW-1:0] psc_i,
    input  logic          hs_tick_i,
    input  logic          lf_tick_i,
    output logic          dec_o
);
    logic [PW-1:0] psc_q;
    logic          sel_tick;
    logic          running;
    clk_src_e      src;

    // decode the selected timebase
    always_comb begin
        src = clk_src_e'(src_i);
        unique case (src)
            SRC_OFF:            sel_tick = 1'b0;
            SRC_HS_A, SRC_HS_B: sel_tick = hs_tick_i;
            default:            sel_tick = lf_tick_i;
        endcase
        running = en_i && (src != SRC_OFF);
        dec_o   = running && sel_tick && (psc_q == psc_i) && !restart_i;
    end

    // count selected ticks up to the prescaler value
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i || restart_i || !running) begin
            psc_q <= '0;
        end else if (sel_tick) begin
            psc_q <= (psc_q == psc_i) ? '0 : psc_q + PW'(1);
        end
    end

    // R3: no decrement without enable or clock source
    assert_stopped_no_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || src_i == 2'b00) |-> !dec_o);

    // R4: with a nonzero prescaler two decrements never come back to back
    assert_psc_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_o && psc_i != '0) |=> !dec_o);
endmodule

// File: rtl/pit_count_core.sv
// Module: the 32-bit down-counter with restart and compare detection.
// A force load wins over a decrement; reset and software reset set all ones.
// Assumes dec_i is a single-cycle pulse from the tick generator.
module pit_count_core #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst_i,
    input  logic          dec_i,
    input  logic          rld_mode_i,
    input  logic [CW-1:0] load_val_i,
    input  logic [CW-1:0] cmp_val_i,
    input  logic          force_i,
    input  logic [CW-1:0] force_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          hit_o
);
    logic [CW-1:0] cnt_q;
    logic          at_zero;

    // zero and compare detection on the current count
    always_comb begin
        at_zero = (cnt_q == '0);
        hit_o   = dec_i && (cnt_q == cmp_val_i);
        cnt_o   = cnt_q;
    end

    // count down, restart at zero, or take a forced value
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            cnt_q <= '1;
        end else if (force_i) begin
            cnt_q <= force_val_i;
        end else if (dec_i) begin
            if (at_zero) begin
                cnt_q <= rld_mode_i ? load_val_i : '1;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // R4: an ordinary decrement steps down by exactly one
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !force_i && !soft_rst_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - CW'(1)));

    // R5: restart from the load register in reload mode
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !force_i && !soft_rst_i && cnt_o == '0 && rld_mode_i) |=> (cnt_o == $past(load_val_i)));

    // R5: wrap to all ones in free-running mode
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !force_i && !soft_rst_i && cnt_o == '0 && !rld_mode_i) |=> (&cnt_o));

    // R9: without decrement or write the count holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i && !force_i && !soft_rst_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pit_regs.sv
// Module: register file of the timer (control, load, compare, status flag)
// and the combinational read mux. Decodes writes into pulses for the
// counter: software reset, restart and forced count loads.
// Assumes one write per cycle and word offsets on bus_addr_i.
module pit_regs
    import pit_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = DATA_W,
    parameter int PW = PSC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    input  logic [DW-1:0] cnt_i,
    input  logic          hit_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          soft_rst_o,
    output logic          ctrl_wr_o,
    output logic          en_o,
    output logic          ocien_o,
    output logic          rld_o,
    output logic [1:0]    src_o,
    output logic [PW-1:0] psc_o,
    output logic [DW-1:0] load_o,
    output logic [DW-1:0] cmp_o,
    output logic          flag_o,
    output logic          force_o,
    output logic [DW-1:0] force_val_o
);
    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_LOAD = AW'(OFS_LOAD);
    localparam logic [AW-1:0] A_CMP  = AW'(OFS_CMP);
    localparam logic [AW-1:0] A_CNT  = AW'(OFS_CNT);

    logic [DW-1:0] ctrl_q, load_q, cmp_q;
    logic          flag_q;
    logic          wr_ctrl, wr_stat, wr_load, wr_cmp;

    // write decode and derived command pulses
    always_comb begin
        wr_ctrl     = bus_wr_i && (bus_addr_i == A_CTRL);
        wr_stat     = bus_wr_i && (bus_addr_i == A_STAT);
        wr_load     = bus_wr_i && (bus_addr_i == A_LOAD);
        wr_cmp      = bus_wr_i && (bus_addr_i == A_CMP);
        soft_rst_o  = wr_ctrl && bus_wdata_i[B_SWR];
        ctrl_wr_o   = wr_ctrl;
        force_o     = 1'b0;
        force_val_o = load_q;
        if (wr_ctrl && !bus_wdata_i[B_SWR] && bus_wdata_i[B_EN] && !bus_wdata_i[B_ENMOD]) begin
            force_o = 1'b1;
        end else if (wr_load && ctrl_q[B_IOVW]) begin
            force_o     = 1'b1;
            force_val_o = bus_wdata_i;
        end
    end

    // control, load and compare storage
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_o) begin
            ctrl_q <= '0;
            load_q <= '1;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata_i & CTRL_KEEP;
            if (wr_load) load_q <= bus_wdata_i;
            if (wr_cmp)  cmp_q  <= bus_wdata_i;
        end
    end

    // sticky status flag: a compare hit wins over an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_o) begin
            flag_q <= 1'b0;
        end else if (hit_i) begin
            flag_q <= 1'b1;
        end else if (wr_stat) begin
            flag_q <= 1'b0;
        end
    end

    // field outputs
    always_comb begin
        en_o    = ctrl_q[B_EN];
        ocien_o = ctrl_q[B_OCIEN];
        rld_o   = ctrl_q[B_RLD];
        src_o   = ctrl_q[SRC_LSB +: 2];
        psc_o   = ctrl_q[PSC_LSB +: PW];
        load_o  = load_q;
        cmp_o   = cmp_q;
        flag_o  = flag_q;
    end

    // read mux
    always_comb begin
        unique case (bus_addr_i)
            A_CTRL:  bus_rdata_o = ctrl_q;
            A_STAT:  bus_rdata_o = {{(DW-1){1'b0}}, flag_q};
            A_LOAD:  bus_rdata_o = load_q;
            A_CMP:   bus_rdata_o = cmp_q;
            A_CNT:   bus_rdata_o = cnt_i;
            default: bus_rdata_o = '0;
        endcase
    end

    // R6: a compare hit leaves the flag set
    assert_hit_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !soft_rst_o) |=> flag_o);

    // R8: an acknowledge without a hit clears the flag
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !hit_i) |=> !flag_o);

    // R11: software reset restores every register
    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (ctrl_q == '0 && (&load_q) && cmp_q == '0 && !flag_q && (&cnt_i)));
endmodule

// File: rtl/pit_timer.sv
// Module: top of the periodic interrupt down-counter. Wires the register
// file, the tick generator and the counter core, and forms the interrupt.
// Assumes tick inputs are already synchronous single-cycle pulses.
module pit_timer
    import pit_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_tick_i,
    input  logic              lf_tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    logic              soft_rst, ctrl_wr, en, ocien, rld, flag, force_ld, dec, hit;
    logic [1:0]        src;
    logic [PSC_W-1:0]  psc;
    logic [DATA_W-1:0] load_val, cmp_val, force_val, cnt;

    pit_regs #(.AW(ADDR_W), .DW(DATA_W), .PW(PSC_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .cnt_i       (cnt),
        .hit_i       (hit),
        .bus_rdata_o (bus_rdata_o),
        .soft_rst_o  (soft_rst),
        .ctrl_wr_o   (ctrl_wr),
        .en_o        (en),
        .ocien_o     (ocien),
        .rld_o       (rld),
        .src_o       (src),
        .psc_o       (psc),
        .load_o      (load_val),
        .cmp_o       (cmp_val),
        .flag_o      (flag),
        .force_o     (force_ld),
        .force_val_o (force_val)
    );

    pit_tick_gen #(.PW(PSC_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .restart_i  (ctrl_wr),
        .en_i       (en),
        .src_i      (src),
        .psc_i      (psc),
        .hs_tick_i  (hs_tick_i),
        .lf_tick_i  (lf_tick_i),
        .dec_o      (dec)
    );

    pit_count_core #(.CW(DATA_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_i  (soft_rst),
        .dec_i       (dec),
        .rld_mode_i  (rld),
        .load_val_i  (load_val),
        .cmp_val_i   (cmp_val),
        .force_i     (force_ld),
        .force_val_i (force_val),
        .cnt_o       (cnt),
        .hit_o       (hit)
    );

    // interrupt request: flag gated by the compare interrupt enable
    always_comb begin
        irq_o = flag && ocien;
    end

    // R7: the interrupt rises only after a compare hit or a control write
    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(hit) || $past(ctrl_wr)));
endmodule

// File: tb/pit_timer_tb.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed scenarios.
module pit_timer_tb;
    localparam logic [31:0] EN    = 32'h1;
    localparam logic [31:0] ENMOD = 32'h2;
    localparam logic [31:0] OCIEN = 32'h4;
    localparam logic [31:0] RLD   = 32'h8;
    localparam logic [31:0] SWR   = 32'h1_0000;
    localparam logic [31:0] IOVW  = 32'h2_0000;
    localparam logic [31:0] FAST  = 32'h0100_0000;

    typedef struct packed {
        logic [31:0] load;
        logic [11:0] psc;
        logic [1:0]  src;
        logic        rld;
        logic [7:0]  hs_n;
        logic [7:0]  lf_n;
        logic [31:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'd100, 12'd0, 2'b01, 1'b1, 8'd5, 8'd0, 32'd95,         1'b0},
        '{32'd100, 12'd2, 2'b01, 1'b1, 8'd9, 8'd3, 32'd97,         1'b0},
        '{32'd100, 12'd1, 2'b11, 1'b1, 8'd4, 8'd6, 32'd97,         1'b0},
        '{32'd100, 12'd0, 2'b00, 1'b1, 8'd5, 8'd5, 32'd100,        1'b0},
        '{32'd3,   12'd0, 2'b10, 1'b1, 8'd5, 8'd0, 32'd2,          1'b1},
        '{32'd3,   12'd0, 2'b01, 1'b0, 8'd5, 8'd0, 32'hFFFF_FFFE,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_tick = 1'b0;
    logic        lf_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pit_timer #(.ADDR_W(4)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_tick_i   (hs_tick),
        .lf_tick_i   (lf_tick),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n, input bit slow);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (slow) lf_tick = 1'b1; else hs_tick = 1'b1;
            @(negedge clk);
            lf_tick = 1'b0; hs_tick = 1'b0;
        end
    endtask

    task automatic read_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 / R1: hardware reset state and unmapped offsets
        read_check("R11 ctrl after reset", 4'd0, 32'h0);
        read_check("R11 status after reset", 4'd1, 32'h0);
        read_check("R11 load after reset", 4'd2, 32'hFFFF_FFFF);
        read_check("R11 cmp after reset", 4'd3, 32'h0);
        read_check("R11 count after reset", 4'd4, 32'hFFFF_FFFF);
        check("R7 irq after reset", {31'b0, irq}, 32'h0);
        read_check("R1 unmapped offset 5", 4'd5, 32'h0);
        read_check("R1 unmapped offset 15", 4'd15, 32'h0);

        // vector table: R3/R4/R5/R6 count after ticks on each timebase
        for (int v = 0; v < NV; v++) begin
            bus_write(4'd0, SWR);
            bus_write(4'd2, VECS[v].load);
            bus_write(4'd0, EN | OCIEN | (VECS[v].rld ? RLD : 32'h0)
                            | ({20'b0, VECS[v].psc} << 4) | ({30'b0, VECS[v].src} << 24));
            ticks(int'(VECS[v].hs_n), 1'b0);
            ticks(int'(VECS[v].lf_n), 1'b1);
            read_check($sformatf("R3/R4/R5 vector %0d count", v), 4'd4, VECS[v].exp_cnt);
            read_check($sformatf("R6 vector %0d flag", v), 4'd1, {31'b0, VECS[v].exp_flag});
            check($sformatf("R7 vector %0d irq", v), {31'b0, irq}, {31'b0, VECS[v].exp_flag});
        end

        // R6/R7: compare hit away from zero, interrupt masked then enabled
        bus_write(4'd0, SWR);
        bus_write(4'd2, 32'd10);
        bus_write(4'd3, 32'd7);
        bus_write(4'd0, EN | RLD | FAST);
        read_check("R9 enable loads count", 4'd4, 32'd10);
        ticks(3, 1'b0);
        read_check("R6 count reaches compare", 4'd4, 32'd7);
        read_check("R6 no flag before hit tick", 4'd1, 32'd0);
        ticks(1, 1'b0);
        read_check("R6 flag after hit tick", 4'd1, 32'd1);
        check("R7 irq masked", {31'b0, irq}, 32'h0);
        bus_write(4'd0, EN | ENMOD | RLD | OCIEN | FAST);
        read_check("R9 enable-mode keeps count", 4'd4, 32'd6);
        check("R7 irq enabled", {31'b0, irq}, 32'h1);

        // R8: acknowledge clears; acknowledge with a hit keeps the flag
        bus_write(4'd1, 32'h0);
        read_check("R8 ack clears flag", 4'd1, 32'd0);
        check("R8 irq after ack", {31'b0, irq}, 32'h0);
        bus_write(4'd3, 32'd5);
        ticks(1, 1'b0);
        read_check("R8 count at new compare", 4'd4, 32'd5);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 32'hFFFF_FFFF; hs_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; hs_tick = 1'b0;
        read_check("R8 hit wins over ack", 4'd1, 32'd1);
        read_check("R8 count after joint cycle", 4'd4, 32'd4);

        // R9: disable holds, enable-mode resumes, plain enable reloads
        bus_write(4'd0, RLD | OCIEN | FAST);
        ticks(3, 1'b0);
        read_check("R9 disabled count holds", 4'd4, 32'd4);
        bus_write(4'd0, EN | ENMOD | FAST);
        ticks(1, 1'b0);
        read_check("R9 resume from held value", 4'd4, 32'd3);
        bus_write(4'd0, EN | FAST);
        read_check("R9 plain enable reloads", 4'd4, 32'd10);

        // R10: load write with and without immediate overwrite
        bus_write(4'd2, 32'd50);
        read_check("R10 count untouched", 4'd4, 32'd10);
        read_check("R10 load updated", 4'd2, 32'd50);
        bus_write(4'd0, EN | ENMOD | IOVW | FAST);
        read_check("R10 count kept on enable-mode", 4'd4, 32'd10);
        bus_write(4'd2, 32'd77);
        read_check("R10 immediate overwrite", 4'd4, 32'd77);

        // R2: stored control fields and forced-zero bits
        bus_write(4'd0, 32'hFFFE_FFFF);
        read_check("R2 control readback", 4'd0, 32'h03FE_FFFF);

        // R11: software reset restores everything
        bus_write(4'd3, 32'd9);
        bus_write(4'd0, SWR | EN | OCIEN);
        read_check("R11 soft reset ctrl", 4'd0, 32'h0);
        read_check("R11 soft reset load", 4'd2, 32'hFFFF_FFFF);
        read_check("R11 soft reset cmp", 4'd3, 32'h0);
        read_check("R11 soft reset count", 4'd4, 32'hFFFF_FFFF);
        read_check("R11 soft reset flag", 4'd1, 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule